// File: doc/BRIEF.md
# Watchdog Supervisor with Start-up Grace Interval

This block supervises software by expecting it to flip one control bit at regular intervals. Once armed, it first waits through a grace interval that runs only once, which gives an operating system room to boot. It then supervises a timeout window. Each flip of the kick bit restarts that window. If the window runs out, the block raises a fixed-length system reset request and records the event in a sticky flag. That flag lives in the power-on reset domain, so it survives the reset the block itself has caused.

Software reaches the block through a byte-wide register port with select, write and read strobes. Configuration inputs set by boot firmware supply the following:
- a global enable;
- an auto-arm option;
- the grace length and the window length, each an 8-bit count of time units;
- the choice of seconds or minutes as the unit.

An internal prescaler divides the clock down to seconds, and then to minutes. After an expiry the block stays halted until software arms it again.

Top module: `wdt_supervisor`

## Requirements
- R1: The control byte reads as bit 0 = armed, bit 1 = kick bit, bit 2 = expiry flag, bits 7..3 = 0. After power-on with auto-arm off it reads 0x00 and `sys_reset_req` is low.
- R2: A write with bit 0 = 1 while disarmed arms the block. The reset request then rises exactly (G+W)·U clock cycles after the clock edge that captured the write. G and W are the grace and window counts, and U is the unit length in cycles.
- R3: The grace interval runs once per arming. A kick restarts only the window, so the next expiry comes W·U cycles after the kick.
- R4: Both a 0→1 and a 1→0 change of bit 1 count as a kick and restart the window.
- R5: Kicks written during the grace interval are ignored, and the expiry time is unchanged.
- R6: Each expiry produces one `sys_reset_req` pulse of exactly PULSE_CYC clock cycles, and the flag is set at the same edge.
- R7: The expiry flag stays set through system reset. Only power-on, or arming the block again, clears it.
- R8: After an expiry the block stays disarmed. Writes that do not arm it produce no further reset request.
- R9: Writing bit 0 = 0 disarms at once, with no reset request.
- R10: With the minutes unit selected, one unit is SECS_PER_MIN seconds.
- R11: With auto-arm on, the block arms itself at the first clock edge after system reset, but only if the flag is clear.
- R12: With the enable input low, writes have no effect, reads return 0x00 and no reset request occurs.
- R13: A grace or window count of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the flag and the pulse generator |
| sys_rst_n | input | 1 | System reset, active low; clears all other state |
| cfg_en | input | 1 | Watchdog enable |
| cfg_autostart | input | 1 | Arm automatically when leaving system reset |
| cfg_minutes | input | 1 | Unit select: 1 = minutes, 0 = seconds |
| cfg_delay | input | 8 | Grace interval in units |
| cfg_timeout | input | 8 | Supervision window in units |
| reg_sel | input | 1 | Register address decode strobe |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, zero when not reading |
| sys_reset_req | output | 1 | Reset request pulse, active high |

## Verification
The bench builds the block with TICKS_PER_SEC = 4, SECS_PER_MIN = 3 and PULSE_CYC = 3. With these values a second lasts four cycles and a minute twelve. Every grace and window expiry, including the minutes unit and the zero-count case, therefore falls within a few dozen cycles, and each one can be checked at its exact edge. The short pulse lets the bench close the loop: it feeds the reset request back into `sys_rst_n`. This shows that the flag survives that reset and that it blocks auto-arming.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned CNT_W = 8;

    typedef enum logic {
        PH_GRACE = 1'b0,
        PH_WATCH = 1'b1
    } phase_e;

    typedef struct packed {
        logic              armed;
        logic              kick;
        logic              boot;
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
    } ctrl_st_t;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int unsigned TICKS_PER_SEC = 50_000_000,
    parameter int unsigned SECS_PER_MIN  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic use_minutes,
    output logic unit_tick
);

    localparam int unsigned SEC_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam int unsigned MIN_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] mins;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     sec_wrap;
    logic     min_wrap;

    generate
        if (TICKS_PER_SEC <= 1) begin : g_sec_bypass
            assign sec_wrap = 1'b1;
        end else begin : g_sec_div
            assign sec_wrap = (st_q.sec == SEC_W'(TICKS_PER_SEC - 1));
        end
        if (SECS_PER_MIN <= 1) begin : g_min_bypass
            assign min_wrap = 1'b1;
        end else begin : g_min_div
            assign min_wrap = (st_q.mins == MIN_W'(SECS_PER_MIN - 1));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.sec  = '0;
            st_d.mins = '0;
        end else if (sec_wrap) begin
            st_d.sec  = '0;
            st_d.mins = min_wrap ? '0 : st_q.mins + MIN_W'(1);
        end else begin
            st_d.sec  = st_q.sec + SEC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unit_tick = sec_wrap && (!use_minutes || min_wrap);

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int unsigned PULSE_CYC = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic fire,
    output logic pulse
);

    localparam int unsigned PW = $clog2(PULSE_CYC + 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0)  cnt_d = cnt_q - PW'(1);
        else if (fire)    cnt_d = PW'(PULSE_CYC);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse = (cnt_q != '0);

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             cfg_en,
    input  logic             cfg_autostart,
    input  logic [CNT_W-1:0] cfg_delay,
    input  logic [CNT_W-1:0] cfg_timeout,
    input  logic             unit_tick,
    input  logic             wr_stb,
    input  logic [7:0]       wr_data,
    output logic             armed,
    output logic             kick,
    output logic             flag,
    output logic             presc_clr,
    output logic             expire
);

    ctrl_st_t st_d, st_q;
    logic     flag_d, flag_q;
    logic     wr_ok;
    logic     toggled;
    logic     arm_now;
    logic     win_reload;
    logic     unused_wdata;

    assign unused_wdata = ^wr_data[7:2];

    always_comb begin
        st_d       = st_q;
        st_d.boot  = 1'b0;
        win_reload = 1'b0;
        expire     = 1'b0;
        wr_ok      = wr_stb && cfg_en;
        toggled    = wr_ok && (wr_data[1] != st_q.kick);
        arm_now    = (wr_ok && wr_data[0] && !st_q.armed) ||
                     (st_q.boot && cfg_en && cfg_autostart && !flag_q);

        if (wr_ok) st_d.kick = wr_data[1];

        if (!cfg_en) begin
            st_d.armed = 1'b0;
        end else if (arm_now) begin
            st_d.armed = 1'b1;
            st_d.phase = PH_GRACE;
            st_d.cnt   = cfg_delay;
        end else if (wr_ok && !wr_data[0]) begin
            st_d.armed = 1'b0;
        end else if (st_q.armed) begin
            if (st_q.phase == PH_WATCH && toggled) begin
                st_d.cnt   = cfg_timeout;
                win_reload = 1'b1;
            end else if (unit_tick) begin
                if (st_q.cnt <= CNT_W'(1)) begin
                    if (st_q.phase == PH_GRACE) begin
                        st_d.phase = PH_WATCH;
                        st_d.cnt   = cfg_timeout;
                    end else begin
                        st_d.armed = 1'b0;
                        expire     = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end

        presc_clr = arm_now || win_reload;

        if (arm_now)     flag_d = 1'b0;
        else if (expire) flag_d = 1'b1;
        else             flag_d = flag_q;
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            st_q       <= '0;
            st_q.boot  <= 1'b1;
            st_q.phase <= PH_GRACE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign armed = st_q.armed;
    assign kick  = st_q.kick;
    assign flag  = flag_q;

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
    parameter int unsigned TICKS_PER_SEC = 50_000_000,
    parameter int unsigned SECS_PER_MIN  = 60,
    parameter int unsigned PULSE_CYC     = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       sys_rst_n,
    input  logic       cfg_en,
    input  logic       cfg_autostart,
    input  logic       cfg_minutes,
    input  logic [7:0] cfg_delay,
    input  logic [7:0] cfg_timeout,
    input  logic       reg_sel,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sys_reset_req
);

    logic unit_tick;
    logic presc_clr;
    logic expire;
    logic armed_w;
    logic kick_w;
    logic flag_w;

    wdt_tick_gen #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .SECS_PER_MIN  (SECS_PER_MIN)
    ) u_tick (
        .clk         (clk),
        .rst_n       (sys_rst_n),
        .clear       (presc_clr),
        .use_minutes (cfg_minutes),
        .unit_tick   (unit_tick)
    );

    wdt_ctrl u_ctrl (
        .clk           (clk),
        .por_n         (por_n),
        .sys_rst_n     (sys_rst_n),
        .cfg_en        (cfg_en),
        .cfg_autostart (cfg_autostart),
        .cfg_delay     (cfg_delay),
        .cfg_timeout   (cfg_timeout),
        .unit_tick     (unit_tick),
        .wr_stb        (reg_sel && reg_wr),
        .wr_data       (reg_wdata),
        .armed         (armed_w),
        .kick          (kick_w),
        .flag          (flag_w),
        .presc_clr     (presc_clr),
        .expire        (expire)
    );

    wdt_pulse #(
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk   (clk),
        .por_n (por_n),
        .fire  (expire),
        .pulse (sys_reset_req)
    );

    assign reg_rdata = (reg_sel && reg_rd && cfg_en) ?
                       {5'b0, flag_w, kick_w, armed_w} : 8'h00;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int unsigned PULSE_CYC = 16
) (
    input logic       clk,
    input logic       por_n,
    input logic       cfg_en,
    input logic       reg_sel,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic       sys_reset_req,
    input logic       flag
);

    int unsigned hi_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)             hi_cnt <= 0;
        else if (sys_reset_req) hi_cnt <= hi_cnt + 1;
        else                    hi_cnt <= 0;
    end

    assert_pulse_bounded_R6: assert property (@(posedge clk) disable iff (!por_n)
        sys_reset_req |-> (hi_cnt < PULSE_CYC));

    assert_pulse_length_R6: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_reset_req) |-> (hi_cnt == PULSE_CYC));

    assert_pulse_sets_flag_R6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_reset_req) |-> flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        (flag && !(reg_sel && reg_wr && reg_wdata[0])) |=> flag);

    assert_halt_after_expiry_R8: assert property (@(posedge clk) disable iff (!por_n)
        (flag && !sys_reset_req) |=> !sys_reset_req);

    assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_en && reg_sel && reg_wr && !reg_wdata[0] && !sys_reset_req) |=> !sys_reset_req);

    assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!por_n)
        (!cfg_en && !sys_reset_req) |=> !sys_reset_req);

endmodule

bind wdt_supervisor wdt_checker #(
    .PULSE_CYC (PULSE_CYC)
) u_wdt_checker (
    .clk           (clk),
    .por_n         (por_n),
    .cfg_en        (cfg_en),
    .reg_sel       (reg_sel),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .sys_reset_req (sys_reset_req),
    .flag          (flag_w)
);

// File: tb/tb_wdt_supervisor.sv
module tb_wdt_supervisor;

    localparam int TPS   = 4;
    localparam int SPM   = 3;
    localparam int PULSE = 3;

    // row = {minutes, grace, window}
    localparam logic [16:0] ROWS [5] = '{
        {1'b0, 8'd1, 8'd1},
        {1'b0, 8'd2, 8'd3},
        {1'b1, 8'd1, 8'd2},
        {1'b0, 8'd0, 8'd2},
        {1'b0, 8'd3, 8'd0}
    };

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_rst_n;
    logic       cfg_en = 1'b1;
    logic       cfg_autostart = 1'b0;
    logic       cfg_minutes = 1'b0;
    logic [7:0] cfg_delay = 8'd1;
    logic [7:0] cfg_timeout = 8'd1;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sys_reset_req;

    int         n_tests = 0;
    int         n_fail = 0;
    int         span;
    int         seen;
    logic [7:0] rv;

    always #4 clk = ~clk;

    assign sys_rst_n = por_n && !sys_reset_req;

    wdt_supervisor #(
        .TICKS_PER_SEC (TPS),
        .SECS_PER_MIN  (SPM),
        .PULSE_CYC     (PULSE)
    ) dut (
        .clk           (clk),
        .por_n         (por_n),
        .sys_rst_n     (sys_rst_n),
        .cfg_en        (cfg_en),
        .cfg_autostart (cfg_autostart),
        .cfg_minutes   (cfg_minutes),
        .cfg_delay     (cfg_delay),
        .cfg_timeout   (cfg_timeout),
        .reg_sel       (reg_sel),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .sys_reset_req (sys_reset_req)
    );

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic rd(output logic [7:0] d);
        reg_sel = 1'b1; reg_rd = 1'b1;
        #1;
        d = reg_rdata;
        reg_sel = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic quiet_for(input int n, output int hits);
        hits = 0;
        repeat (n) begin
            @(negedge clk);
            if (sys_reset_req) hits++;
        end
    endtask

    task automatic power_cycle;
        por_n = 1'b0;
        cyc(2);
        por_n = 1'b1;
        cyc(1);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        // R1: reset state
        power_cycle();
        rd(rv);
        check("R1 read after power-on", rv, 8'h00);
        check("R1 reset request idle", sys_reset_req, 1'b0);

        // table walk: R2, R6, R7, R10, R13
        for (int i = 0; i < 5; i++) begin
            cfg_minutes = ROWS[i][16];
            cfg_delay   = ROWS[i][15:8];
            cfg_timeout = ROWS[i][7:0];
            span = (eff(cfg_delay) + eff(cfg_timeout)) * TPS * (cfg_minutes ? SPM : 1);
            wr(8'h01);
            cyc(span - 1);
            check($sformatf("R2 R10 R13 row %0d quiet before expiry", i), sys_reset_req, 1'b0);
            cyc(1);
            check($sformatf("R2 R10 R13 row %0d expiry edge", i), sys_reset_req, 1'b1);
            cyc(PULSE - 1);
            check($sformatf("R6 row %0d pulse still high", i), sys_reset_req, 1'b1);
            cyc(1);
            check($sformatf("R6 row %0d pulse ended", i), sys_reset_req, 1'b0);
            rd(rv);
            check($sformatf("R7 row %0d flag after reset", i), rv, 8'h04);
        end

        // R3, R4: kicks in the window restart only the window
        cfg_minutes = 1'b0; cfg_delay = 8'd2; cfg_timeout = 8'd3;
        wr(8'h01);
        cyc(10);
        wr(8'h03);
        cyc(6);
        check("R4 rising kick keeps quiet", sys_reset_req, 1'b0);
        wr(8'h01);
        cyc(11);
        check("R3 R4 falling kick reload quiet", sys_reset_req, 1'b0);
        cyc(1);
        check("R3 expiry one window after kick", sys_reset_req, 1'b1);
        cyc(PULSE);

        // R5: kicks during grace are ignored
        cfg_delay = 8'd2; cfg_timeout = 8'd1;
        wr(8'h01);
        cyc(2);
        wr(8'h03);
        cyc(2);
        wr(8'h01);
        cyc(5);
        check("R5 quiet before original deadline", sys_reset_req, 1'b0);
        cyc(1);
        check("R5 expiry at original deadline", sys_reset_req, 1'b1);
        cyc(PULSE);

        // R9: disarm stops without reset
        cfg_delay = 8'd1; cfg_timeout = 8'd1;
        wr(8'h01);
        cyc(3);
        wr(8'h00);
        quiet_for(30, seen);
        check("R9 no reset after disarm", seen, 0);
        rd(rv);
        check("R9 readback after disarm", rv, 8'h00);

        // R8, R7: halted after expiry, flag sticky, cleared by arming
        wr(8'h01);
        cyc(7);
        check("R8 quiet before expiry", sys_reset_req, 1'b0);
        cyc(1);
        check("R8 expiry", sys_reset_req, 1'b1);
        cyc(PULSE);
        wr(8'h02);
        wr(8'h00);
        quiet_for(40, seen);
        check("R8 no further reset while halted", seen, 0);
        rd(rv);
        check("R7 flag kept after kicks", rv, 8'h04);
        wr(8'h01);
        rd(rv);
        check("R7 flag cleared by arming", rv, 8'h01);
        wr(8'h00);

        // R11: auto-arm at boot, blocked once the flag is set
        cfg_delay = 8'd1; cfg_timeout = 8'd2; cfg_autostart = 1'b1;
        power_cycle();
        rd(rv);
        check("R11 armed at boot", rv, 8'h01);
        cyc(11);
        check("R11 quiet before expiry", sys_reset_req, 1'b0);
        cyc(1);
        check("R11 expiry after auto-arm", sys_reset_req, 1'b1);
        cyc(PULSE);
        quiet_for(30, seen);
        check("R11 no auto-arm with flag set", seen, 0);
        rd(rv);
        check("R11 R7 flag survives, not armed", rv, 8'h04);

        // R12: disabled block ignores everything
        cfg_autostart = 1'b0; cfg_en = 1'b0;
        power_cycle();
        wr(8'h01);
        wr(8'h02);
        quiet_for(40, seen);
        check("R12 no reset while disabled", seen, 0);
        rd(rv);
        check("R12 read returns zero while disabled", rv, 8'h00);
        cfg_en = 1'b1;
        rd(rv);
        check("R12 writes left no state", rv, 8'h00);

        summary();
    end

endmodule